// File: doc/BRIEF.md
# Lock-Gated Configuration Register Bank with Open-Window Timeout

This block guards a small bank of critical configuration registers against stray or unprivileged writes. A lock bit, set out of reset, blocks every protected write. Software first writes a 16-bit password to a lock control register to open the lock. While the lock is open, writes issued in supervisor mode reach the bank. Any other write to a protected location is dropped, and the block pulses an alarm for it.

Opening the lock also starts a down-counter loaded from a programmable reload register. If software does not close the lock, again with the password, before the counter runs out, the block closes the lock itself. It then latches a fault that stays set until reset. A wrong password leaves the lock as it was and raises a separate alarm. Reads are never gated.

The address map is as follows. Address 0 is the lock control register. Address 1 is the timeout reload register, which is protected. Addresses 2 to NUM_PROT+1 form the protected bank. Every other address is unmapped.

Top module: `initLockGate`

## Requirements
- R1: After reset the lock is closed (lockClosed=1), faultLatched=0, both alarms are 0, the reload register reads 0xFFFF and every bank register reads 0.
- R2: A write to the reload register (address 1) or to a bank register (addresses 2..NUM_PROT+1) is stored only when the lock is open and wrSuper=1. The new value can be read from the cycle after the write edge.
- R3: A write to a protected address made while the lock is closed or with wrSuper=0 is dropped, and the register keeps its value. discardAlarm is high for exactly one cycle after that write edge. A write to address 0 with wrSuper=0 is dropped in the same way and has no effect on the lock.
- R4: A supervisor write to address 0 opens the lock when wrData[31:16] equals PASSWORD and wrData[0]=0. Reading address 0 returns the lock bit in bit 0, the fault flag in bit 1, and 0 in all other bits.
- R5: A supervisor write to address 0 whose wrData[31:16] differs from PASSWORD leaves the lock unchanged and pulses pwdAlarm for one cycle.
- R6: A supervisor write to address 0 with the correct password and wrData[0]=1 closes the lock and stops the timer. If this write lands on the same edge on which the timer would expire, the close wins and no fault is raised.
- R7: Opening the lock loads the timer with the reload value R. If the lock is still open R+1 clock edges after the opening edge, faultLatched rises at that edge and the lock is forced closed.
- R8: Once faultLatched is set, it stays set until reset and the lock stays closed. A correct-password open request is then refused and pulses discardAlarm.
- R9: Reads through rdAddr/rdData are combinational and always allowed, whether the lock is open or closed.
- R10: Writes to unmapped addresses change nothing and raise no alarm.
- R11: A correct-password open request made while the lock is already open reloads the timer, so the timeout is counted again from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data; for address 0, [31:16] is the password and [0] is the requested lock bit |
| wrSuper | input | 1 | Write is issued in supervisor mode |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, combinational |
| lockClosed | output | 1 | Current lock bit |
| faultLatched | output | 1 | Timeout fault, sticky until reset |
| discardAlarm | output | 1 | One-cycle pulse when a write is dropped |
| pwdAlarm | output | 1 | One-cycle pulse on a password mismatch |

## Verification
The bench targets the exact expiry edge. It sets a short reload, checks that the fault stays low through edge R and rises at edge R+1, and checks that a close landing on edge R+1 beats the expiry. A counter off by one, or a close with the wrong priority, would move the fault by one edge or raise it despite a timely close. The bench also checks that a user-mode write with the lock open is dropped and the value kept. A design that looked only at the lock bit would store that write. Once the fault is latched, the bench sends a correct-password open request. A design whose fault was not sticky would reopen and take protected writes.

// File: rtl/initlock_pkg.sv
package initlock_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic bankWe;    // store to the bank register selected by wrAddr
    logic reloadWe;  // store to the timeout reload register
  } wrStrobe_t;
endpackage

// File: rtl/initLockCtrl.sv
module initLockCtrl
  import initlock_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_PROT = 4,
  parameter int PWD_W    = 16,
  parameter int TMO_W    = 16,
  parameter logic [PWD_W-1:0] PASSWORD = 16'hC35A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSuper,
  input  logic [TMO_W-1:0]  reloadVal,
  output wrStrobe_t         strobe,
  output logic              lockClosed,
  output logic              faultLatched,
  output logic              discardAlarm,
  output logic              pwdAlarm
);
  localparam int BANK_LAST = NUM_PROT + 1;
  localparam logic [ADDR_W-1:0] LOCK_ADDR   = '0;
  localparam logic [ADDR_W-1:0] RELOAD_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LAST_ADDR   = ADDR_W'(BANK_LAST);

  logic [TMO_W-1:0] count;
  logic isLockWr, isProtWr, pwdOk, reqOpen, reqClose, allowProt, expire;

  always_comb begin
    isLockWr  = wrEn && (wrAddr == LOCK_ADDR);
    isProtWr  = wrEn && (wrAddr >= RELOAD_ADDR) && (wrAddr <= LAST_ADDR);
    pwdOk     = (wrData[DATA_W-1 -: PWD_W] == PASSWORD);
    allowProt = !lockClosed && wrSuper;
    reqOpen   = isLockWr && wrSuper && pwdOk && !wrData[0] && !faultLatched;
    reqClose  = isLockWr && wrSuper && pwdOk && wrData[0];
    expire    = !lockClosed && (count == '0) && !reqClose && !reqOpen;
    strobe.bankWe   = isProtWr && allowProt && (wrAddr != RELOAD_ADDR);
    strobe.reloadWe = isProtWr && allowProt && (wrAddr == RELOAD_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockClosed   <= 1'b1;
      faultLatched <= 1'b0;
      count        <= '0;
      discardAlarm <= 1'b0;
      pwdAlarm     <= 1'b0;
    end else begin
      discardAlarm <= (isProtWr && !allowProt)
                    || (isLockWr && !wrSuper)
                    || (isLockWr && wrSuper && pwdOk && !wrData[0] && faultLatched);
      pwdAlarm     <= isLockWr && wrSuper && !pwdOk;
      if (reqOpen) begin
        lockClosed <= 1'b0;
        count      <= reloadVal;
      end else if (reqClose) begin
        lockClosed <= 1'b1;
      end else if (expire) begin
        lockClosed   <= 1'b1;
        faultLatched <= 1'b1;
      end else if (!lockClosed) begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/initLockData.sv
module initLockData
  import initlock_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_PROT = 4,
  parameter int TMO_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              lockClosed,
  input  logic              faultLatched,
  output logic [TMO_W-1:0]  reloadVal,
  output logic [DATA_W-1:0] rdData
);
  localparam int BANK_BASE = 2;

  logic [DATA_W-1:0] bank [NUM_PROT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadVal <= '1;
    else if (strobe.reloadWe) reloadVal <= wrData[TMO_W-1:0];
  end

  for (genvar g = 0; g < NUM_PROT; g++) begin : gBank
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BANK_BASE + g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bank[g] <= '0;
      else if (strobe.bankWe && wrAddr == MY_ADDR) bank[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) begin
      rdData[1:0] = {faultLatched, lockClosed};
    end else if (rdAddr == ADDR_W'(1)) begin
      rdData[TMO_W-1:0] = reloadVal;
    end else begin
      for (int i = 0; i < NUM_PROT; i++)
        if (rdAddr == ADDR_W'(BANK_BASE + i)) rdData = bank[i];
    end
  end
endmodule

// File: rtl/initLockGate.sv
module initLockGate
  import initlock_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_PROT = 4,
  parameter int PWD_W    = 16,
  parameter int TMO_W    = 16,
  parameter logic [PWD_W-1:0] PASSWORD = 16'hC35A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSuper,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              lockClosed,
  output logic              faultLatched,
  output logic              discardAlarm,
  output logic              pwdAlarm
);
  wrStrobe_t        strobe;
  logic [TMO_W-1:0] reloadVal;

  initLockCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
    .PWD_W(PWD_W), .TMO_W(TMO_W), .PASSWORD(PASSWORD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrSuper(wrSuper), .reloadVal(reloadVal), .strobe(strobe),
    .lockClosed(lockClosed), .faultLatched(faultLatched),
    .discardAlarm(discardAlarm), .pwdAlarm(pwdAlarm)
  );

  initLockData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT), .TMO_W(TMO_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .lockClosed(lockClosed), .faultLatched(faultLatched),
    .reloadVal(reloadVal), .rdData(rdData)
  );
endmodule

// File: rtl/initLockGateChk.sv
module initLockGateChk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_PROT = 4,
  parameter int PWD_W    = 16,
  parameter logic [PWD_W-1:0] PASSWORD = 16'hC35A
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrSuper,
  input logic              lockClosed,
  input logic              faultLatched,
  input logic              discardAlarm,
  input logic              pwdAlarm
);
  logic protHit, lockHit, pwdMatch;
  assign protHit  = wrEn && wrAddr >= ADDR_W'(1) && wrAddr <= ADDR_W'(NUM_PROT + 1);
  assign lockHit  = wrEn && wrAddr == '0;
  assign pwdMatch = wrData[DATA_W-1 -: PWD_W] == PASSWORD;

  p_discard_r3: assert property (@(posedge clk) disable iff (!rstN)
    protHit && (lockClosed || !wrSuper) |=> discardAlarm);
  p_open_r4: assert property (@(posedge clk) disable iff (!rstN)
    lockHit && wrSuper && pwdMatch && !wrData[0] && !faultLatched |=> !lockClosed);
  p_bad_pwd_r5: assert property (@(posedge clk) disable iff (!rstN)
    lockHit && wrSuper && !pwdMatch && lockClosed |=> pwdAlarm && lockClosed);
  p_close_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockHit && wrSuper && pwdMatch && wrData[0] |=> lockClosed && $stable(faultLatched));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |=> faultLatched && lockClosed);
  p_fault_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> $past(!lockClosed));
endmodule

bind initLockGate initLockGateChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
  .PWD_W(PWD_W), .PASSWORD(PASSWORD)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .wrSuper(wrSuper), .lockClosed(lockClosed), .faultLatched(faultLatched),
  .discardAlarm(discardAlarm), .pwdAlarm(pwdAlarm)
);

// File: tb/tb_initLockGate.sv
module tb_initLockGate;
  localparam int AW = 4, DW = 32, NP = 4;
  localparam logic [15:0] PWD = 16'hC35A;

  logic clk = 0, rstN = 0, wrEn = 0, wrSuper = 0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0, rdData;
  logic lockClosed, faultLatched, discardAlarm, pwdAlarm;
  int total = 0, bad = 0;
  bit done = 0;
  logic lastDisc, lastPwd;
  logic [31:0] mBank [NP];
  logic mLock;

  always #4 clk = ~clk;

  initLockGate dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d, input logic s);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d; wrSuper = s;
    @(posedge clk); #1;
    wrEn = 0;
    lastDisc = discardAlarm; lastPwd = pwdAlarm;
  endtask

  function automatic logic [31:0] lockWord(input logic [15:0] p, input bit lockBit);
    return {p, 15'h0, lockBit};
  endfunction

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); rdAddr = a; #1; v = rdData;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    chk(lockClosed === 1, "R1 lock", {31'h0, lockClosed}, 1);
    chk(faultLatched === 0 && discardAlarm === 0 && pwdAlarm === 0, "R1 flags", 0, 0);
    rd(1, v); chk(v === 32'hFFFF, "R1 reload", v, 32'hFFFF);
    for (int i = 0; i < NP; i++) begin
      rd(AW'(i + 2), v); chk(v === 0, "R1 bank", v, 0);
      mBank[i] = 0;
    end
    // R3 write while locked
    doWrite(2, 32'h1111_2222, 1);
    chk(lastDisc === 1, "R3 alarm locked", {31'h0, lastDisc}, 1);
    rd(2, v); chk(v === 0, "R3 kept", v, 0);
    // R3 lock reg non-supervisor
    doWrite(0, lockWord(PWD, 0), 0);
    chk(lastDisc === 1 && lockClosed === 1, "R3 user lock write", {30'h0, lastDisc, lockClosed}, 3);
    // R5 wrong password
    doWrite(0, lockWord(PWD ^ 16'h0001, 0), 1);
    chk(lastPwd === 1 && lockClosed === 1, "R5 bad pwd", {30'h0, lastPwd, lockClosed}, 3);
    // R4 open and readback
    doWrite(0, lockWord(PWD, 0), 1);
    chk(lockClosed === 0 && lastPwd === 0, "R4 open", {31'h0, lockClosed}, 0);
    rd(0, v); chk(v === 0, "R4 status read", v, 0);
    // R2 supervisor write with open lock
    doWrite(3, 32'hDEAD_BEEF, 1);
    rd(3, v); chk(v === 32'hDEAD_BEEF && lastDisc === 0, "R2 store", v, 32'hDEAD_BEEF);
    mBank[1] = 32'hDEAD_BEEF;
    // R3 user write with open lock
    doWrite(3, 32'h0BAD_0BAD, 0);
    rd(3, v); chk(v === 32'hDEAD_BEEF && lastDisc === 1, "R3 user open", v, 32'hDEAD_BEEF);
    // R10 unmapped
    doWrite(AW'(15), 32'h5555_5555, 1);
    rd(AW'(15), v); chk(v === 0 && lastDisc === 0 && lastPwd === 0, "R10 unmapped", v, 0);
    // R6 close
    doWrite(0, lockWord(PWD, 1), 1);
    chk(lockClosed === 1, "R6 close", {31'h0, lockClosed}, 1);
    // R9 reads while locked
    rd(3, v); chk(v === 32'hDEAD_BEEF, "R9 read locked", v, 32'hDEAD_BEEF);

    // random phase, reload stays 0xFFFF
    mLock = 1;
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 4);
      case (op)
        0: begin doWrite(0, lockWord(PWD, 0), 1); mLock = 0; end
        1: begin doWrite(0, lockWord(PWD, 1), 1); mLock = 1; end
        2: begin
          int idx = $urandom_range(0, NP - 1);
          logic s = 1'($urandom_range(0, 1));
          logic [31:0] d = $urandom;
          bit ok = !mLock && s;
          doWrite(AW'(idx + 2), d, s);
          if (ok) mBank[idx] = d;
          chk(lastDisc === !ok, "R3 random alarm", {31'h0, lastDisc}, {31'h0, !ok});
          rd(AW'(idx + 2), v);
          chk(v === mBank[idx], "R2 random bank", v, mBank[idx]);
        end
        3: begin
          doWrite(0, lockWord(PWD ^ 16'($urandom_range(1, 65535)), 0), 1);
          chk(lastPwd === 1 && lockClosed === mLock, "R5 random bad pwd", {31'h0, lockClosed}, {31'h0, mLock});
        end
        default: begin
          int idx = $urandom_range(0, NP - 1);
          rd(AW'(idx + 2), v);
          chk(v === mBank[idx], "R9 random read", v, mBank[idx]);
        end
      endcase
    end
    doWrite(0, lockWord(PWD, 1), 1);

    // R7 / R6 timeout with reload 5
    doWrite(0, lockWord(PWD, 0), 1);
    doWrite(1, 32'd5, 1);
    rd(1, v); chk(v === 5, "R2 reload write", v, 5);
    doWrite(0, lockWord(PWD, 1), 1);
    // close on expiry edge wins
    doWrite(0, lockWord(PWD, 0), 1);
    repeat (5) @(posedge clk);
    doWrite(0, lockWord(PWD, 1), 1);
    chk(faultLatched === 0 && lockClosed === 1, "R6 close wins", {31'h0, faultLatched}, 0);
    // R11 reopen restarts
    doWrite(0, lockWord(PWD, 0), 1);
    repeat (3) @(posedge clk);
    doWrite(0, lockWord(PWD, 0), 1);
    repeat (5) @(posedge clk);
    #1 chk(faultLatched === 0 && lockClosed === 0, "R11 restart", {31'h0, faultLatched}, 0);
    @(posedge clk); #1;
    chk(faultLatched === 1 && lockClosed === 1, "R7 fault at R+1", {30'h0, faultLatched, lockClosed}, 3);
    rd(0, v); chk(v === 3, "R4 status fault", v, 3);
    // R8 sticky, reopen refused
    doWrite(0, lockWord(PWD, 0), 1);
    chk(lockClosed === 1 && lastDisc === 1, "R8 refuse open", {30'h0, lockClosed, lastDisc}, 3);
    doWrite(2, 32'h7777_7777, 1);
    rd(2, v); chk(v === mBank[0], "R8 bank safe", v, mBank[0]);
    repeat (20) @(posedge clk);
    #1 chk(faultLatched === 1, "R8 sticky", {31'h0, faultLatched}, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule